// File: doc/BRIEF.md
# Serial EEPROM Slave with Whole-Array Erase and Fill

This block is the slave side of a small three-wire serial EEPROM, with a chip select, a serial clock, a data input and a data output. It holds a register array of `2**ADDR_W` words of `DATA_W` bits, 64 words of 16 bits by default. A host selects the device, clocks in a start bit, a two-bit opcode and an address, and then a data word if the command takes one. The slave serves single-word read, write and erase. It also serves two whole-array commands: one sets every bit of the array to 1, and one copies a single shifted-in word into every location.

Write-type commands are guarded by a write-enable latch. When the host releases chip select after a complete write-type frame, the slave runs an internal cycle of fixed length. While that cycle runs, it shows busy (0) on the data output whenever chip select is high, and it shows ready (1) once the cycle has finished. All pins are sampled through synchronisers on the system clock. The serial clock is therefore expected to be several times slower than the system clock.

Top module: `uwire_eeprom_bulk`

## Requirements
- R1: After reset, every word reads all-ones, write-enable is clear, no internal cycle runs, and the data output is 0.
- R2: A frame is sampled on serial-clock rising edges while chip select is high. Leading 0 bits are skipped until a 1 start bit arrives. The start bit is followed by a 2-bit opcode and then an ADDR_W-bit address, each sent MSB first.
- R3: Opcode 10 is a read. After the last address bit the data output shows a 0 dummy bit. Each following rising edge then presents the next bit of the addressed word, MSB first.
- R4: Opcode 01 writes the DATA_W-bit word that follows the address into that one location. Opcode 11 sets that one location to all-ones.
- R5: Opcode 00 with address bits [ADDR_W-1:ADDR_W-2] = 11 sets write-enable, and with 00 clears it. Any erase or write frame that arrives while write-enable is clear changes nothing.
- R6: Opcode 00 with top address bits 10 sets every word to all-ones. The low address bits are a don't-care.
- R7: Opcode 00 with top address bits 01, followed by one DATA_W-bit word, writes that word into every location. The low address bits are a don't-care.
- R8: A write-type command takes effect only when chip select falls after its frame is complete. A frame cut short by an early chip-select fall is discarded.
- R9: The internal cycle lasts exactly BUSY_CYCLES system clocks and begins at most SYNC_STAGES+1 clocks after chip select falls. Once the cycle is launched and until the next start bit, the data output (with chip select high) is 0 during the cycle and 1 after it.
- R10: Frames sent while an internal cycle runs are ignored.
- R11: The data output is 0 whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Chip select, active high |
| ser_clk | input | 1 | Serial clock, data sampled on its rising edge |
| ser_in | input | 1 | Serial data from host |
| ser_out | output | 1 | Read data, or busy/ready status after a write-type command |

## Verification
The hardest situation to reach is a second command arriving while an internal cycle still runs. The bench sets the cycle length well above the length of a full write frame. It launches one write, then at once sends a complete write frame to another address and releases chip select before the first cycle ends. Reading both locations afterwards shows that only the first write landed. Incomplete frames and write-type frames sent with write-enable clear are also covered. Each is followed straight away by a read, which returns no data if a cycle was started by mistake.

// File: rtl/uwb_pkg.sv
package uwb_pkg;

   localparam logic [1:0] OPC_EXT   = 2'b00;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_ERASE = 2'b11;

   localparam logic [1:0] EXT_LOCK  = 2'b00;
   localparam logic [1:0] EXT_FILL  = 2'b01;
   localparam logic [1:0] EXT_BLANK = 2'b10;
   localparam logic [1:0] EXT_OPEN  = 2'b11;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_READ,
      CMD_WRITE,
      CMD_ERASE,
      CMD_FILL,
      CMD_BLANK,
      CMD_OPEN,
      CMD_LOCK
   } uwb_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADR,
      ST_DAT,
      ST_RD,
      ST_DONE
   } uwb_state_e;

   function automatic uwb_cmd_e uwb_decode(logic [1:0] opc, logic [1:0] ext);
      uwb_cmd_e c;
      case (opc)
         OPC_READ:  c = CMD_READ;
         OPC_WRITE: c = CMD_WRITE;
         OPC_ERASE: c = CMD_ERASE;
         default: begin
            case (ext)
               EXT_FILL:  c = CMD_FILL;
               EXT_BLANK: c = CMD_BLANK;
               EXT_OPEN:  c = CMD_OPEN;
               default:   c = CMD_LOCK;
            endcase
         end
      endcase
      return c;
   endfunction

   function automatic logic uwb_needs_data(uwb_cmd_e c);
      return (c == CMD_WRITE) || (c == CMD_FILL);
   endfunction

   function automatic logic uwb_is_store(uwb_cmd_e c);
      return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_FILL) || (c == CMD_BLANK);
   endfunction

endpackage

// File: rtl/uwb_sync.sv
module uwb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/uwb_busy_timer.sv
module uwb_busy_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   localparam int CNT_W = $clog2(CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   assign done = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= LOAD;
      end else if (done) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/uwb_array.sv
module uwb_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic              fill_all,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_val,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_word
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH*DATA_W-1:0] flat;

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      localparam logic [ADDR_W-1:0] IDX = ADDR_W'(w);
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '1;
         else if (commit && (fill_all || (wr_addr == IDX)))
            word_q <= wr_val;
      end
      assign flat[w*DATA_W +: DATA_W] = word_q;
   end

   assign rd_word = flat[rd_addr*DATA_W +: DATA_W];

endmodule

// File: rtl/uwb_frame_decoder.sv
module uwb_frame_decoder
   import uwb_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              bit_stb,
   input  logic              din,
   input  logic [DATA_W-1:0] rd_word,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              frame_ok,
   output uwb_cmd_e          cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data,
   output logic              dout_bit,
   output logic              start_stb,
   output uwb_state_e        state_o
);

   localparam int MAXB  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
   localparam int CNT_W = $clog2(MAXB + 1);
   localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADDR_W - 1);
   localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

   uwb_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [1:0]        opc;
   logic [DATA_W-1:0] shreg;
   logic [ADDR_W-1:0] addr_next;
   uwb_cmd_e          cmd_next;

   assign addr_next = {addr[ADDR_W-2:0], din};
   assign rd_addr   = addr_next;
   assign cmd_next  = uwb_decode(opc, addr_next[ADDR_W-1 -: 2]);
   assign start_stb = bit_stb && (state == ST_IDLE) && din;
   assign state_o   = state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         opc      <= '0;
         addr     <= '0;
         data     <= '0;
         shreg    <= '0;
         cmd      <= CMD_NONE;
         frame_ok <= 1'b0;
         dout_bit <= 1'b0;
      end else if (!sel) begin
         state    <= ST_IDLE;
         frame_ok <= 1'b0;
         dout_bit <= 1'b0;
      end else if (bit_stb) begin
         case (state)
            ST_IDLE: begin
               if (din) begin
                  state <= ST_OPC;
                  cnt   <= '0;
               end
            end
            ST_OPC: begin
               opc <= {opc[0], din};
               if (cnt == CNT_W'(1)) begin
                  state <= ST_ADR;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_ADR: begin
               addr <= addr_next;
               if (cnt == ADR_LAST) begin
                  cmd <= cmd_next;
                  cnt <= '0;
                  if (cmd_next == CMD_READ) begin
                     shreg    <= rd_word;
                     dout_bit <= 1'b0;
                     state    <= ST_RD;
                  end else if (uwb_needs_data(cmd_next)) begin
                     state <= ST_DAT;
                  end else begin
                     frame_ok <= 1'b1;
                     state    <= ST_DONE;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DAT: begin
               data <= {data[DATA_W-2:0], din};
               if (cnt == DAT_LAST) begin
                  frame_ok <= 1'b1;
                  state    <= ST_DONE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_RD: begin
               dout_bit <= shreg[DATA_W-1];
               shreg    <= {shreg[DATA_W-2:0], 1'b0};
            end
            default: begin
               state <= state;
            end
         endcase
      end
   end

endmodule

// File: rtl/uwire_eeprom_bulk.sv
module uwire_eeprom_bulk
   import uwb_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int BUSY_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_sel,
   input  logic ser_clk,
   input  logic ser_in,
   output logic ser_out
);

   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W must lie in 2..12");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic cs_s, sk_s, di_s;
   logic cs_prev, sk_prev;
   logic cs_fall, sk_rise, bit_stb;

   uwb_sync #(.STAGES(SYNC_STAGES)) u_sync_cs (.clk(clk), .rst_n(rst_n), .d(chip_sel), .q(cs_s));
   uwb_sync #(.STAGES(SYNC_STAGES)) u_sync_sk (.clk(clk), .rst_n(rst_n), .d(ser_clk),  .q(sk_s));
   uwb_sync #(.STAGES(SYNC_STAGES)) u_sync_di (.clk(clk), .rst_n(rst_n), .d(ser_in),   .q(di_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev <= 1'b0;
         sk_prev <= 1'b0;
      end else begin
         cs_prev <= cs_s;
         sk_prev <= sk_s;
      end
   end

   assign cs_fall = cs_prev && !cs_s;
   assign sk_rise = sk_s && !sk_prev;

   logic              busy, done;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_word;
   logic              frame_ok, dec_dout, start_stb;
   uwb_cmd_e          dec_cmd;
   logic [ADDR_W-1:0] dec_addr;
   logic [DATA_W-1:0] dec_data;
   uwb_state_e        dec_state;

   assign bit_stb = sk_rise && cs_s && !busy;

   uwb_frame_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (cs_s),
      .bit_stb   (bit_stb),
      .din       (di_s),
      .rd_word   (rd_word),
      .rd_addr   (rd_addr),
      .frame_ok  (frame_ok),
      .cmd       (dec_cmd),
      .addr      (dec_addr),
      .data      (dec_data),
      .dout_bit  (dec_dout),
      .start_stb (start_stb),
      .state_o   (dec_state)
   );

   logic              wen_q, status_q;
   logic              pend_all;
   logic [ADDR_W-1:0] pend_addr;
   logic [DATA_W-1:0] pend_val;
   logic              accept, launch;

   assign accept = cs_fall && !busy && frame_ok;
   assign launch = accept && wen_q && uwb_is_store(dec_cmd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q     <= 1'b0;
         status_q  <= 1'b0;
         pend_all  <= 1'b0;
         pend_addr <= '0;
         pend_val  <= '0;
      end else begin
         if (accept && dec_cmd == CMD_OPEN) wen_q <= 1'b1;
         if (accept && dec_cmd == CMD_LOCK) wen_q <= 1'b0;
         if (launch) begin
            status_q  <= 1'b1;
            pend_all  <= (dec_cmd == CMD_FILL) || (dec_cmd == CMD_BLANK);
            pend_addr <= dec_addr;
            pend_val  <= ((dec_cmd == CMD_ERASE) || (dec_cmd == CMD_BLANK)) ? '1 : dec_data;
         end else if (start_stb) begin
            status_q <= 1'b0;
         end
      end
   end

   uwb_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (launch),
      .busy  (busy),
      .done  (done)
   );

   uwb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (done),
      .fill_all (pend_all),
      .wr_addr  (pend_addr),
      .wr_val   (pend_val),
      .rd_addr  (rd_addr),
      .rd_word  (rd_word)
   );

   assign ser_out = cs_s && (status_q ? !busy : dec_dout);

endmodule

// File: rtl/uwb_checker.sv
module uwb_checker
   import uwb_pkg::*;
#(
   parameter int BUSY_CYCLES = 1000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       wen,
   input logic       cs_lvl,
   input uwb_state_e dec_state,
   input logic       dout_bit
);

   int   run;
   logic cs_d1, cs_d2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 0;
         cs_d1 <= 1'b0;
         cs_d2 <= 1'b0;
      end else begin
         run   <= busy ? run + 1 : 0;
         cs_d1 <= cs_lvl;
         cs_d2 <= cs_d1;
      end
   end

   // R9: cycle length
   assert_busy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run == BUSY_CYCLES);

   // R5: no cycle without write-enable
   assert_launch_wen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wen));

   // R8: cycle begins right after a chip-select fall
   assert_launch_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!cs_d1 && cs_d2));

   // R10: frame state frozen while busy
   assert_frozen_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cs_lvl) |=> ($stable(dec_state) || !cs_lvl));

   // R3: read starts with a 0 dummy bit
   assert_read_dummy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((dec_state == ST_RD) && ($past(dec_state) != ST_RD)) |-> !dout_bit);

endmodule

bind uwire_eeprom_bulk uwb_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .wen       (wen_q),
   .cs_lvl    (cs_s),
   .dec_state (dec_state),
   .dout_bit  (dec_dout)
);

// File: tb/tb_uwire_eeprom_bulk.sv
module tb_uwire_eeprom_bulk;

   localparam int AW   = 6;
   localparam int DW   = 16;
   localparam int BUSY = 1000;
   localparam int SYNC = 2;
   localparam int HP   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chip_sel = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_in = 1'b0;
   logic ser_out;

   int errors = 0;
   int checks = 0;

   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] act_q[$];
   string         tag_q[$];
   event          rd_ev;

   always #2 clk = ~clk;

   uwire_eeprom_bulk #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BUSY), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel),
      .ser_clk(ser_clk), .ser_in(ser_in), .ser_out(ser_out)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(logic b);
      @(negedge clk);
      ser_in = b;
      idle(HP);
      ser_clk = 1'b1;
      idle(HP);
      ser_clk = 1'b0;
   endtask

   task automatic frame_begin();
      @(negedge clk);
      chip_sel = 1'b1;
      idle(HP);
   endtask

   task automatic frame_end();
      @(negedge clk);
      ser_clk  = 1'b0;
      chip_sel = 1'b0;
   endtask

   task automatic send_cmd(logic [1:0] opc, logic [AW-1:0] a, int ndata, logic [DW-1:0] d);
      frame_begin();
      send_bit(1'b1);
      send_bit(opc[1]);
      send_bit(opc[0]);
      for (int i = AW - 1; i >= 0; i--) send_bit(a[i]);
      for (int i = 0; i < ndata; i++) send_bit(d[DW-1-i]);
      frame_end();
   endtask

   // driver: queues the expected word, then collects the shifted-out word
   task automatic read_word(logic [AW-1:0] a, logic [DW-1:0] exp, string tag, int nlead);
      logic [DW-1:0] w;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      frame_begin();
      for (int i = 0; i < nlead; i++) send_bit(1'b0);
      send_bit(1'b1);
      send_bit(1'b1);
      send_bit(1'b0);
      for (int i = AW - 1; i >= 0; i--) send_bit(a[i]);
      chk({tag, " R3 dummy bit"}, 32'(ser_out), 32'h0);
      w = '0;
      for (int i = 0; i < DW; i++) begin
         send_bit(1'b0);
         w = {w[DW-2:0], ser_out};
      end
      frame_end();
      idle(4);
      chk("R11 output low when deselected", 32'(ser_out), 32'h0);
      idle(12);
      act_q.push_back(w);
      -> rd_ev;
   endtask

   // monitor: pops expected items and compares with results
   initial begin
      forever begin
         @(rd_ev);
         while (act_q.size() != 0 && exp_q.size() != 0) begin
            logic [DW-1:0] a_w, e_w;
            string t;
            a_w = act_q.pop_front();
            e_w = exp_q.pop_front();
            t   = tag_q.pop_front();
            chk(t, 32'(a_w), 32'(e_w));
         end
      end
   end

   // waits for the cycle after chip select fell; optionally checks its length
   task automatic wait_ready(string tag, bit timed);
      int n;
      n = 0;
      repeat (6) begin @(negedge clk); n++; end
      chip_sel = 1'b1;
      repeat (4) begin @(negedge clk); n++; end
      chk({tag, " R9 busy shown"}, 32'(ser_out), 32'h0);
      while (ser_out !== 1'b1 && n < 3 * BUSY) begin
         @(negedge clk);
         n++;
      end
      chk({tag, " R9 ready shown"}, 32'(ser_out), 32'h1);
      if (timed)
         chk("R9 cycle length in window", 32'((n >= BUSY) && (n <= BUSY + SYNC + 1)), 32'h1);
      @(negedge clk);
      chip_sel = 1'b0;
      idle(16);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(5);
      chk("R1 output low in reset", 32'(ser_out), 32'h0);
      rst_n = 1'b1;
      idle(5);
      chk("R1 output low after reset", 32'(ser_out), 32'h0);
      read_word(6'd5, 16'hFFFF, "R1 erased after reset", 0);

      // write-type commands while write-enable is clear: R5
      send_cmd(2'b01, 6'd3, DW, 16'h1234);
      idle(16);
      read_word(6'd3, 16'hFFFF, "R5 write ignored when locked", 0);
      send_cmd(2'b00, 6'b100000, 0, '0);
      idle(16);
      read_word(6'd3, 16'hFFFF, "R5 erase-all ignored when locked", 0);

      // enable writes, single write R4
      send_cmd(2'b00, 6'b110000, 0, '0);
      idle(16);
      send_cmd(2'b01, 6'd3, DW, 16'h1234);
      wait_ready("write3", 1'b1);
      read_word(6'd3, 16'h1234, "R4 single write", 0);
      read_word(6'd4, 16'hFFFF, "R4 neighbour untouched", 0);
      send_cmd(2'b01, 6'd63, DW, 16'hA5C3);
      wait_ready("write63", 1'b0);
      read_word(6'd63, 16'hA5C3, "R4 write top address", 0);

      // single erase R4
      send_cmd(2'b11, 6'd3, 0, '0);
      wait_ready("erase3", 1'b0);
      read_word(6'd3, 16'hFFFF, "R4 single erase", 0);
      read_word(6'd63, 16'hA5C3, "R4 erase leaves others", 0);

      // write-all with nonzero dummy bits R7
      send_cmd(2'b00, 6'b010101, DW, 16'hBEEF);
      wait_ready("fill", 1'b1);
      read_word(6'd0, 16'hBEEF, "R7 fill word 0", 0);
      read_word(6'd17, 16'hBEEF, "R7 fill word 17", 0);
      read_word(6'd63, 16'hBEEF, "R7 fill word 63", 0);

      // erase-all with nonzero dummy bits R6
      send_cmd(2'b00, 6'b101010, 0, '0);
      wait_ready("blank", 1'b1);
      read_word(6'd0, 16'hFFFF, "R6 blank word 0", 0);
      read_word(6'd30, 16'hFFFF, "R6 blank word 30", 0);
      read_word(6'd63, 16'hFFFF, "R6 blank word 63", 0);

      // second frame while busy R10
      send_cmd(2'b01, 6'd10, DW, 16'h1111);
      idle(8);
      send_cmd(2'b01, 6'd11, DW, 16'h2222);
      wait_ready("busyframe", 1'b0);
      read_word(6'd11, 16'hFFFF, "R10 frame during busy ignored", 0);
      read_word(6'd10, 16'h1111, "R10 first write kept", 0);

      // truncated frame R8
      send_cmd(2'b01, 6'd12, 8, 16'h5A5A);
      idle(16);
      read_word(6'd12, 16'hFFFF, "R8 truncated frame discarded", 0);

      // leading zeros before the start bit R2
      read_word(6'd10, 16'h1111, "R2 leading zeros skipped", 3);

      // disable writes again R5
      send_cmd(2'b00, 6'b001111, 0, '0);
      idle(16);
      send_cmd(2'b01, 6'd20, DW, 16'h0F0F);
      idle(16);
      read_word(6'd20, 16'hFFFF, "R5 write ignored after lock", 0);
      send_cmd(2'b00, 6'b100000, 0, '0);
      idle(16);
      read_word(6'd10, 16'h1111, "R5 erase-all ignored after lock", 0);

      idle(20);
      chk("scoreboard drained", 32'(exp_q.size()), 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule